// File: doc/BRIEF.md
# Round-Robin Quantum Scheduler

This block decides which of a fixed set of tasks owns the processor. Each task raises a ready level while it can run and gives a one-cycle I/O-done pulse when a wait on I/O completes. A time base delivers tick pulses, and the running task keeps the processor for a programmable number of ticks. The block then selects again. The selection also happens at once when the running task stops being ready, or when nothing is running.

A selection first looks at tasks that have an I/O return pending and are ready now. Only when no such task exists does it look at all ready tasks. In both cases the search goes in circular order and starts with the task after the one that ran last. A pulse marks every selection. When no task is ready, the block reports idle and keeps the ID of the last task that ran.

Top module: `quantum_sched`

## Requirements
- R1: While `rstN` is low the outputs are `curValid`=0, `switchStb`=0 and `curTask`=0, and all pending I/O returns are cleared.
- R2: While a task runs, every cycle with `tick` high adds one to its slice count. On the tick that brings the count to the effective quantum, a new selection is made, and it appears on the outputs in the following cycle.
- R3: A selection considers tasks in the circular order curTask+1, curTask+2, ..., wrapping modulo `NUM_TASKS` and ending with curTask. It takes the first candidate found.
- R4: A pulse on `ioDoneVec[i]` marks task i pending from the next cycle onward. When any pending task is ready, the selection chooses only among those pending ready tasks.
- R5: A task's pending mark clears when that task is selected. Several pending tasks are therefore served in the R3 order, one per selection.
- R6: If `readyVec[curTask]` is low while a task runs, a new selection is made in that cycle regardless of the slice count. The new task starts with a slice count of zero.
- R7: If a selection finds no ready task, `curValid` goes low, `switchStb` stays low and `curTask` keeps its value. The block then tries again every cycle.
- R8: A `quantumLen` of 0 selects the default quantum of `DEFAULT_QUANTUM` ticks (100). Any other value is the quantum itself.
- R9: `switchStb` is high for exactly one cycle per selection, together with the new `curTask`. This also holds when the same task is chosen again. `curTask` changes only on such cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| readyVec | input | NUM_TASKS | Per-task ready level |
| ioDoneVec | input | NUM_TASKS | Per-task I/O return pulse |
| tick | input | 1 | Time-base pulse |
| quantumLen | input | QUANTUM_W | Slice length in ticks; 0 means default |
| curTask | output | $clog2(NUM_TASKS) | Task now running, or last run when idle |
| curValid | output | 1 | A task is running |
| switchStb | output | 1 | One-cycle pulse on each selection |

## Verification
The first pattern leaves two widely spaced tasks ready and ticks every cycle with a short quantum. This shows whether the rotation skips non-ready slots and wraps correctly. The second pattern makes all tasks ready and ticks sparsely, which separates counting ticks from counting cycles. Other patterns drop the running task's ready bit in mid-slice, pulse I/O returns for several tasks at once, and pulse one for a task that is not yet ready. These show that the early reselect works, that boosted tasks go before others in round-robin order, and that a pending mark waits for readiness. Finally, a single ready task, an all-idle stretch and a zero quantum length separate same-task reselection, idle holding and the default quantum.

// File: rtl/quantum_sched_pkg.sv
package quantum_sched_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic doSelect;
    logic goIdle;
    logic countUp;
  } schedCtl_t;
endpackage

// File: rtl/quantum_sched_ctrl.sv
module quantum_sched_ctrl
  import quantum_sched_pkg::*;
(
  input  logic      curValid,
  input  logic      curReady,
  input  logic      tick,
  input  logic      sliceHit,
  input  logic      anyCand,
  output schedCtl_t ctl
);
  logic needPick;

  always_comb begin
    needPick     = !curValid || !curReady || (tick && sliceHit);
    ctl.doSelect = needPick && anyCand;
    ctl.goIdle   = needPick && !anyCand;
    ctl.countUp  = !needPick && tick;
  end
endmodule

// File: rtl/quantum_sched_dp.sv
module quantum_sched_dp
  import quantum_sched_pkg::*;
#(
  parameter int NUM_TASKS       = 8,
  parameter int QUANTUM_W       = 16,
  parameter int DEFAULT_QUANTUM = 100,
  localparam int TIDW           = $clog2(NUM_TASKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_TASKS-1:0] readyVec,
  input  logic [NUM_TASKS-1:0] ioDoneVec,
  input  logic [QUANTUM_W-1:0] quantumLen,
  input  schedCtl_t            ctl,
  output logic                 curReady,
  output logic                 sliceHit,
  output logic                 anyCand,
  output logic [TIDW-1:0]      curTask,
  output logic                 curValid,
  output logic                 switchStb,
  output logic [NUM_TASKS-1:0] boostPend
);
  logic [QUANTUM_W-1:0] sliceCnt;
  logic [QUANTUM_W-1:0] effQuantum;
  logic [QUANTUM_W:0]   cntPlusOne;
  logic [NUM_TASKS-1:0] boostRdy;
  logic [NUM_TASKS-1:0] candVec;
  logic [TIDW-1:0]      pickIdx;
  logic [NUM_TASKS-1:0] pickMask;

  always_comb begin
    effQuantum = (quantumLen == '0) ? QUANTUM_W'(DEFAULT_QUANTUM) : quantumLen;
    cntPlusOne = {1'b0, sliceCnt} + 1'b1;
    sliceHit   = cntPlusOne >= {1'b0, effQuantum};
    curReady   = readyVec[curTask];
    boostRdy   = boostPend & readyVec;
    candVec    = (|boostRdy) ? boostRdy : readyVec;
    anyCand    = |readyVec;
  end

  // circular search after curTask; smallest distance wins
  always_comb begin
    pickIdx = curTask;
    for (int k = NUM_TASKS; k >= 1; k--) begin
      int j;
      j = (int'(curTask) + k) % NUM_TASKS;
      if (candVec[j]) pickIdx = TIDW'(j);
    end
    pickMask = '0;
    pickMask[pickIdx] = ctl.doSelect;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sliceCnt  <= '0;
      curTask   <= '0;
      curValid  <= 1'b0;
      switchStb <= 1'b0;
      boostPend <= '0;
    end else begin
      switchStb <= ctl.doSelect;
      boostPend <= (boostPend & ~pickMask) | ioDoneVec;
      if (ctl.doSelect) begin
        curTask  <= pickIdx;
        curValid <= 1'b1;
        sliceCnt <= '0;
      end else if (ctl.goIdle) begin
        curValid <= 1'b0;
      end else if (ctl.countUp) begin
        sliceCnt <= sliceCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/quantum_sched.sv
module quantum_sched
  import quantum_sched_pkg::*;
#(
  parameter int NUM_TASKS       = 8,
  parameter int QUANTUM_W       = 16,
  parameter int DEFAULT_QUANTUM = 100,
  localparam int TIDW           = $clog2(NUM_TASKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_TASKS-1:0] readyVec,
  input  logic [NUM_TASKS-1:0] ioDoneVec,
  input  logic                 tick,
  input  logic [QUANTUM_W-1:0] quantumLen,
  output logic [TIDW-1:0]      curTask,
  output logic                 curValid,
  output logic                 switchStb
);
  schedCtl_t            ctl;
  logic                 curReady;
  logic                 sliceHit;
  logic                 anyCand;
  logic [NUM_TASKS-1:0] boostPend;

  quantum_sched_ctrl u_ctrl (
    .curValid (curValid),
    .curReady (curReady),
    .tick     (tick),
    .sliceHit (sliceHit),
    .anyCand  (anyCand),
    .ctl      (ctl)
  );

  quantum_sched_dp #(
    .NUM_TASKS       (NUM_TASKS),
    .QUANTUM_W       (QUANTUM_W),
    .DEFAULT_QUANTUM (DEFAULT_QUANTUM)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .readyVec   (readyVec),
    .ioDoneVec  (ioDoneVec),
    .quantumLen (quantumLen),
    .ctl        (ctl),
    .curReady   (curReady),
    .sliceHit   (sliceHit),
    .anyCand    (anyCand),
    .curTask    (curTask),
    .curValid   (curValid),
    .switchStb  (switchStb),
    .boostPend  (boostPend)
  );
endmodule

// File: rtl/quantum_sched_chk.sv
module quantum_sched_chk #(
  parameter int NUM_TASKS = 8,
  localparam int TIDW     = $clog2(NUM_TASKS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_TASKS-1:0] readyVec,
  input logic [NUM_TASKS-1:0] boostPend,
  input logic [TIDW-1:0]      curTask,
  input logic                 curValid,
  input logic                 switchStb
);
  AST_STB_MEANS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    switchStb |-> curValid); // R9
  AST_TASK_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !switchStb |-> $stable(curTask)); // R9
  AST_PICK_WAS_READY: assert property (@(posedge clk) disable iff (!rstN)
    switchStb |-> ((($past(readyVec) >> curTask) & 1) != 0)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !curValid |-> !switchStb); // R7
  AST_IDLE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(curValid) |-> ($past(readyVec) == '0)); // R7
  AST_BOOST_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (switchStb && ($past(boostPend & readyVec) != '0))
      |-> ((($past(boostPend) >> curTask) & 1) != 0)); // R4
endmodule

bind quantum_sched quantum_sched_chk #(.NUM_TASKS(NUM_TASKS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .readyVec  (readyVec),
  .boostPend (boostPend),
  .curTask   (curTask),
  .curValid  (curValid),
  .switchStb (switchStb)
);

// File: tb/quantum_sched_tb.sv
module quantum_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 8;
  localparam int QW = 16;
  localparam int WATCHDOG = 100000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NT-1:0] readyVec = '0;
  logic [NT-1:0] ioDoneVec = '0;
  logic          tick = 1'b0;
  logic [QW-1:0] quantumLen = '0;
  logic [2:0]    curTask;
  logic          curValid;
  logic          switchStb;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  string curReq = "R1";

  // reference model state
  int mTask = 0;
  bit mValid = 0;
  bit mStb = 0;
  int mCnt = 0;
  bit [NT-1:0] mPend = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quantum_sched u_dut (
    .clk(clk), .rstN(rstN), .readyVec(readyVec), .ioDoneVec(ioDoneVec),
    .tick(tick), .quantumLen(quantumLen),
    .curTask(curTask), .curValid(curValid), .switchStb(switchStb)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d", curReq, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mTask = 0; mValid = 0; mStb = 0; mCnt = 0; mPend = '0;
    end else begin
      int effQ;
      int found;
      bit need;
      effQ = (quantumLen == 0) ? 100 : int'(quantumLen);
      need = !mValid || !readyVec[mTask] || (tick && (mCnt + 1 >= effQ));
      mStb = 0;
      if (need) begin
        found = -1;
        for (int k = 1; k <= NT; k++)
          if (found < 0 && mPend[(mTask+k)%NT] && readyVec[(mTask+k)%NT]) found = (mTask+k)%NT;
        for (int k = 1; k <= NT; k++)
          if (found < 0 && readyVec[(mTask+k)%NT]) found = (mTask+k)%NT;
        if (found >= 0) begin
          mTask = found; mValid = 1; mCnt = 0; mStb = 1; mPend[found] = 0;
        end else mValid = 0;
      end else if (tick) mCnt++;
      mPend = mPend | ioDoneVec;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(curValid == mValid, "curValid", curValid, mValid);
      check(switchStb == mStb, "switchStb", switchStb, mStb);
      if (mValid) check(int'(curTask) == mTask, "curTask", curTask, mTask);
    end
  end

  task automatic run(input int n, input int tickEvery);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = (tickEvery > 0) && ((i % tickEvery) == 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    check(curValid == 0, "reset curValid", curValid, 0);
    check(switchStb == 0, "reset switchStb", switchStb, 0);
    check(curTask == 0, "reset curTask", curTask, 0);
    rstN = 1'b1;

    // R2 R3: sparse ready set, tick every cycle, short quantum
    curReq = "R3"; quantumLen = 3; readyVec = 8'b0100_0010;
    run(30, 1);
    curReq = "R2"; quantumLen = 4; readyVec = 8'hFF;
    run(60, 3);

    // R6: running task blocks mid-slice
    curReq = "R6"; quantumLen = 20;
    for (int r = 0; r < 4; r++) begin
      run(5, 1);
      @(negedge clk); readyVec = 8'hFF & ~(8'd1 << mTask);
      @(negedge clk); readyVec = 8'hFF;
    end

    // R4 R5: several I/O returns at once, then one for a not-ready task
    curReq = "R4";
    @(negedge clk); ioDoneVec = 8'b1001_0100;
    @(negedge clk); ioDoneVec = '0;
    run(30, 1);
    curReq = "R5"; readyVec = 8'b0000_1111;
    @(negedge clk); ioDoneVec = 8'b0010_0000;
    @(negedge clk); ioDoneVec = '0;
    run(25, 1);
    readyVec = 8'hFF;
    run(25, 1);

    // R9: single ready task reselected
    curReq = "R9"; quantumLen = 2; readyVec = 8'b0000_1000;
    run(12, 1);

    // R7: idle
    curReq = "R7"; readyVec = '0;
    run(10, 1);
    readyVec = 8'b0001_0000;
    run(5, 1);

    // R8: default quantum
    curReq = "R8"; quantumLen = 0; readyVec = 8'b0000_0011;
    run(320, 1);

    done = 1;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > WATCHDOG);
    done = 1;
    curReq = "watchdog";
    check(0, "timeout", cycles, WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule